// File: doc/BRIEF.md
# Key-Value Query Classifier

This block sits in a switch pipeline after the L2-L4 parser. It watches a stream of 32-bit header words that starts at the UDP word. A packet whose UDP destination port equals a configured service port is taken as a key-value request. From the application header that follows, the block pulls out an 8-bit opcode, a 32-bit sequence number and a 128-bit key.

When the last key word arrives, the block reads a cache hit flag from the lookup stage. It combines that flag with the opcode to pick what happens to the packet:

- answer from the cache and turn the packet back toward the client;
- drop the cached copy and forward the request;
- forward the request to the storage server;
- write a value into the cache.

Packets on any other port are marked as plain traffic and take no action.

Each packet yields one registered result with a single-cycle valid pulse. A downstream stage acts on the action flags. That stage returns cache replies by swapping the packet's addresses, and it updates the hit and miss counters.

Top module: `kvq_classifier`

## Requirements
- R1: After reset `o_valid` and all action flags (`o_reply`, `o_swap`, `o_inval`, `o_fwd`, `o_cache_wr`, `o_stat_hit`, `o_stat_miss`, `o_unknown`) are 0. Action flags are 0 in every cycle where `o_valid` is 0.
- R2: A start word (`i_valid` and `i_sop`) whose bits [15:0] differ from `KV_PORT` yields one `o_valid` pulse in the cycle after that word. In that pulse `o_is_kv` is 0 and all action flags are 0. The remaining words of that packet produce no pulse.
- R3: For a packet on `KV_PORT`, the words after the start word are laid out as follows. Word 1 carries the opcode in bits [31:24]. Word 2 is the sequence number. Words 3 to 6 are the key, most significant word first. The result pulses in the cycle after word 6, with `o_is_kv`=1 and the fields as sent.
- R4: Opcode read (0x01) with hit=1 gives `o_reply`, `o_swap` and `o_stat_hit`, and no `o_fwd`.
- R5: Read with hit=0 gives `o_fwd` and `o_stat_miss` only.
- R6: Write (0x02) with hit=1 gives `o_inval` and `o_fwd`. Write with hit=0 gives `o_fwd` only.
- R7: Delete (0x03) gives the same flags as write for both hit values.
- R8: Cache update (0x04) gives `o_cache_wr` only, for either hit value.
- R9: Any other opcode gives `o_fwd` and `o_unknown` only.
- R10: `i_hit` is sampled only in the cycle of the last key word. Its value in other cycles has no effect.
- R11: A start word arriving in the middle of a request restarts parsing. Cycles with `i_valid`=0 inside a packet stall parsing without losing state.
- R12: Words with `i_valid`=1 and `i_sop`=0 that arrive while no request is open produce no pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| i_valid | input | 1 | Header word valid |
| i_sop | input | 1 | First word of a packet (UDP ports word) |
| i_data | input | 32 | Header word |
| i_hit | input | 1 | Cache hit flag for the key, valid with the last key word |
| o_valid | output | 1 | One-cycle result pulse |
| o_is_kv | output | 1 | Packet is a key-value request |
| o_op | output | 8 | Extracted opcode |
| o_seq | output | 32 | Extracted sequence number |
| o_key | output | 128 | Extracted key |
| o_reply | output | 1 | Answer from the cache |
| o_swap | output | 1 | Swap addresses to return the packet |
| o_inval | output | 1 | Invalidate the cached entry |
| o_fwd | output | 1 | Forward to the storage server |
| o_cache_wr | output | 1 | Write the value into the cache |
| o_stat_hit | output | 1 | Bump hit statistics |
| o_stat_miss | output | 1 | Bump miss statistics |
| o_unknown | output | 1 | Opcode not recognised |

## Verification
The bench sends every opcode with both hit values. A decoder that mixed up the write and delete paths, or that let a read hit also forward, would produce wrong flags there.

It raises `i_hit` on the cycles before and after the last key word but not on that word itself. A design that latched the flag too early would then answer from the cache by mistake.

It also covers several packet shapes:
- a request with idle gaps;
- a request cut short by a new start word;
- stray words with no open request;
- a non-service port packet followed by more words.

A wrong word counter would misplace the key, fire a second pulse, or treat a fragment as a request.

// File: rtl/kvq_pkg.sv
package kvq_pkg;
  localparam int OP_W = 8;
  localparam logic [OP_W-1:0] OP_READ   = 8'h01;
  localparam logic [OP_W-1:0] OP_WRITE  = 8'h02;
  localparam logic [OP_W-1:0] OP_DELETE = 8'h03;
  localparam logic [OP_W-1:0] OP_UPDATE = 8'h04;

  typedef struct packed {
    logic reply;
    logic swap;
    logic inval;
    logic fwd;
    logic cache_wr;
    logic stat_hit;
    logic stat_miss;
    logic unknown;
  } kvq_act_t;
endpackage

// File: rtl/kvq_hdr_parse.sv
module kvq_hdr_parse
  import kvq_pkg::*;
#(
  parameter int W       = 32,
  parameter int KEY_W   = 128,
  parameter int KV_PORT = 8888
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic             i_sop,
  input  logic [W-1:0]     i_data,
  output logic             o_done,
  output logic             o_is_kv,
  output logic [OP_W-1:0]  o_op,
  output logic [W-1:0]     o_seq,
  output logic [KEY_W-1:0] o_key
);
  localparam int KEY_WORDS = KEY_W / W;
  localparam int LAST_IDX  = 2 + KEY_WORDS;
  localparam int CNT_W     = $clog2(LAST_IDX + 1);

  logic             active;
  logic [CNT_W-1:0] cnt;
  logic [OP_W-1:0]  op_q;
  logic [W-1:0]     seq_q;
  logic [KEY_W-1:0] key_q;
  logic             port_match;
  logic             body_word;
  logic             last_word;
  logic [KEY_W+W-1:0] key_cat;

  assign port_match = (i_data[15:0] == KV_PORT[15:0]);
  assign body_word  = i_valid && !i_sop && active;
  assign last_word  = body_word && (cnt == CNT_W'(LAST_IDX));
  assign key_cat    = {key_q, i_data};

  always_ff @(posedge clk) begin
    if (rst) begin
      active <= 1'b0;
      cnt    <= '0;
      op_q   <= '0;
      seq_q  <= '0;
      key_q  <= '0;
    end else if (i_valid && i_sop) begin
      active <= port_match;
      cnt    <= CNT_W'(1);
    end else if (body_word) begin
      if (cnt == CNT_W'(1)) op_q  <= i_data[W-1 -: OP_W];
      if (cnt == CNT_W'(2)) seq_q <= i_data;
      if (cnt >= CNT_W'(3)) key_q <= key_cat[KEY_W-1:0];
      if (last_word) active <= 1'b0;
      else           cnt    <= cnt + CNT_W'(1);
    end
  end

  assign o_done  = (i_valid && i_sop && !port_match) || last_word;
  assign o_is_kv = !i_sop;
  assign o_op    = op_q;
  assign o_seq   = seq_q;
  assign o_key   = key_cat[KEY_W-1:0];

  a_r3_cnt_in_range: assert property (@(posedge clk) disable iff (rst)
    active |-> (cnt >= CNT_W'(1) && cnt <= CNT_W'(LAST_IDX)));
  a_r12_done_needs_word: assert property (@(posedge clk) disable iff (rst)
    (o_done && !i_sop) |-> $past(active));
endmodule

// File: rtl/kvq_disp_decode.sv
module kvq_disp_decode
  import kvq_pkg::*;
(
  input  logic            i_is_kv,
  input  logic [OP_W-1:0] i_op,
  input  logic            i_hit,
  output kvq_act_t        o_act
);
  always_comb begin
    o_act = '0;
    if (i_is_kv) begin
      unique case (i_op)
        OP_READ: begin
          if (i_hit) begin
            o_act.reply    = 1'b1;
            o_act.swap     = 1'b1;
            o_act.stat_hit = 1'b1;
          end else begin
            o_act.fwd       = 1'b1;
            o_act.stat_miss = 1'b1;
          end
        end
        OP_WRITE, OP_DELETE: begin
          o_act.fwd   = 1'b1;
          o_act.inval = i_hit;
        end
        OP_UPDATE: o_act.cache_wr = 1'b1;
        default: begin
          o_act.fwd     = 1'b1;
          o_act.unknown = 1'b1;
        end
      endcase
    end
  end
endmodule

// File: rtl/kvq_classifier.sv
module kvq_classifier
  import kvq_pkg::*;
#(
  parameter int W       = 32,
  parameter int KEY_W   = 128,
  parameter int KV_PORT = 8888
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             i_valid,
  input  logic             i_sop,
  input  logic [W-1:0]     i_data,
  input  logic             i_hit,
  output logic             o_valid,
  output logic             o_is_kv,
  output logic [OP_W-1:0]  o_op,
  output logic [W-1:0]     o_seq,
  output logic [KEY_W-1:0] o_key,
  output logic             o_reply,
  output logic             o_swap,
  output logic             o_inval,
  output logic             o_fwd,
  output logic             o_cache_wr,
  output logic             o_stat_hit,
  output logic             o_stat_miss,
  output logic             o_unknown
);
  logic             p_done, p_is_kv;
  logic [OP_W-1:0]  p_op;
  logic [W-1:0]     p_seq;
  logic [KEY_W-1:0] p_key;
  kvq_act_t         d_act, act_q;

  kvq_hdr_parse #(.W(W), .KEY_W(KEY_W), .KV_PORT(KV_PORT)) u_parse (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_sop(i_sop), .i_data(i_data),
    .o_done(p_done), .o_is_kv(p_is_kv), .o_op(p_op), .o_seq(p_seq), .o_key(p_key)
  );

  kvq_disp_decode u_dec (
    .i_is_kv(p_is_kv), .i_op(p_op), .i_hit(i_hit), .o_act(d_act)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      o_valid <= 1'b0;
      o_is_kv <= 1'b0;
      o_op    <= '0;
      o_seq   <= '0;
      o_key   <= '0;
      act_q   <= '0;
    end else begin
      o_valid <= p_done;
      act_q   <= p_done ? d_act : '0;
      if (p_done) begin
        o_is_kv <= p_is_kv;
        o_op    <= p_is_kv ? p_op  : '0;
        o_seq   <= p_is_kv ? p_seq : '0;
        o_key   <= p_is_kv ? p_key : '0;
      end
    end
  end

  assign o_reply     = act_q.reply;
  assign o_swap      = act_q.swap;
  assign o_inval     = act_q.inval;
  assign o_fwd       = act_q.fwd;
  assign o_cache_wr  = act_q.cache_wr;
  assign o_stat_hit  = act_q.stat_hit;
  assign o_stat_miss = act_q.stat_miss;
  assign o_unknown   = act_q.unknown;

  a_r1_flags_need_valid: assert property (@(posedge clk) disable iff (rst)
    !o_valid |-> (act_q == '0));
  a_r2_plain_no_action: assert property (@(posedge clk) disable iff (rst)
    (o_valid && !o_is_kv) |-> (act_q == '0));
  a_r4_reply_turns_back: assert property (@(posedge clk) disable iff (rst)
    o_reply |-> (o_swap && o_stat_hit && !o_fwd && !o_stat_miss));
  a_r8_update_not_forwarded: assert property (@(posedge clk) disable iff (rst)
    o_cache_wr |-> (!o_fwd && !o_reply && !o_inval));
  a_r11_pulse_from_word: assert property (@(posedge clk) disable iff (rst)
    o_valid |-> $past(i_valid));
  a_r6_inval_forwards: assert property (@(posedge clk) disable iff (rst)
    o_inval |-> (o_fwd && !o_reply));
endmodule

// File: tb/kvq_classifier_tb.sv
module kvq_classifier_tb;
  localparam int CLK_PERIOD = 10;
  localparam int PORT = 8888;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic i_valid = 1'b0, i_sop = 1'b0, i_hit = 1'b0;
  logic [31:0] i_data = '0;
  logic o_valid, o_is_kv;
  logic [7:0] o_op;
  logic [31:0] o_seq;
  logic [127:0] o_key;
  logic o_reply, o_swap, o_inval, o_fwd, o_cache_wr, o_stat_hit, o_stat_miss, o_unknown;
  int n_checks = 0, n_fail = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  kvq_classifier u_dut (
    .clk(clk), .rst(rst), .i_valid(i_valid), .i_sop(i_sop), .i_data(i_data), .i_hit(i_hit),
    .o_valid(o_valid), .o_is_kv(o_is_kv), .o_op(o_op), .o_seq(o_seq), .o_key(o_key),
    .o_reply(o_reply), .o_swap(o_swap), .o_inval(o_inval), .o_fwd(o_fwd),
    .o_cache_wr(o_cache_wr), .o_stat_hit(o_stat_hit), .o_stat_miss(o_stat_miss),
    .o_unknown(o_unknown)
  );

  function automatic logic [7:0] flags();
    return {o_reply, o_swap, o_inval, o_fwd, o_cache_wr, o_stat_hit, o_stat_miss, o_unknown};
  endfunction

  // Flag order: reply swap inval fwd cache_wr stat_hit stat_miss unknown
  function automatic logic [7:0] exp_flags(input logic [7:0] op, input logic hit);
    case (op)
      8'h01: return hit ? 8'b1100_0100 : 8'b0001_0010;
      8'h02, 8'h03: return hit ? 8'b0011_0000 : 8'b0001_0000;
      8'h04: return 8'b0000_1000;
      default: return 8'b0001_0001;
    endcase
  endfunction

  task automatic check(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic word(input logic sop, input logic [31:0] d, input logic hit);
    i_valid = 1'b1; i_sop = sop; i_data = d; i_hit = hit;
    @(negedge clk);
    i_valid = 1'b0; i_sop = 1'b0; i_hit = 1'b0;
  endtask

  // Sends a request on the service port; hit only during the last key word.
  // gap: idle cycle between words; noise: hit raised on idle/other words.
  task automatic send_req(input logic [7:0] op, input logic [31:0] seq,
                          input logic [127:0] key, input logic hit,
                          input bit gap, input bit noise, input string req);
    word(1'b1, {16'd1234, PORT[15:0]}, noise);
    if (gap) begin i_hit = noise; @(negedge clk); i_hit = 0; end
    word(1'b0, {op, 24'h0}, noise);
    word(1'b0, seq, noise);
    if (gap) begin @(negedge clk); check({req, " no early pulse"}, o_valid, 0); end
    for (int k = 0; k < 3; k++) begin
      word(1'b0, key[127-32*k -: 32], noise);
      check({req, " no pulse mid"}, o_valid, 0);
    end
    word(1'b0, key[31:0], hit);
    check({req, " valid"}, o_valid, 1);
    check({req, " is_kv"}, o_is_kv, 1);
    check({req, " op"}, o_op, op);
    check({req, " seq"}, o_seq, seq);
    check({req, " key"}, o_key, key);
    check({req, " flags"}, flags(), exp_flags(op, hit));
    i_hit = noise;
    @(negedge clk);
    i_hit = 0;
    check({req, " single pulse"}, o_valid, 0);
    check({req, " flags clear"}, flags(), 0);
  endtask

  task automatic t_reset();
    check("R1 reset valid", o_valid, 0);
    check("R1 reset flags", flags(), 0);
  endtask

  task automatic t_opcodes();
    send_req(8'h01, 32'h11, 128'h0123456789abcdef_fedcba9876543210, 1, 0, 0, "R4 read hit R3");
    send_req(8'h01, 32'h22, 128'h55, 0, 0, 0, "R5 read miss");
    send_req(8'h02, 32'h33, 128'hdead, 1, 0, 0, "R6 write hit");
    send_req(8'h02, 32'h44, 128'hbeef, 0, 0, 0, "R6 write miss");
    send_req(8'h03, 32'h55, 128'h1, 1, 0, 0, "R7 delete hit");
    send_req(8'h03, 32'h66, 128'h2, 0, 0, 0, "R7 delete miss");
    send_req(8'h04, 32'h77, 128'h3, 1, 0, 0, "R8 update hit");
    send_req(8'h04, 32'h88, 128'h4, 0, 0, 0, "R8 update miss");
    send_req(8'h09, 32'h99, 128'h5, 1, 0, 0, "R9 unknown op");
  endtask

  task automatic t_hit_window();
    send_req(8'h01, 32'haaaa_5555, {4{32'hc0ffee00}}, 0, 1, 1, "R10 hit noise R11 gaps");
  endtask

  task automatic t_plain();
    word(1'b1, {16'd8888, 16'd80}, 1);
    check("R2 plain valid", o_valid, 1);
    check("R2 plain is_kv", o_is_kv, 0);
    check("R2 plain flags", flags(), 0);
    for (int k = 0; k < 7; k++) begin
      word(1'b0, {8'h01, 24'h0}, 1);
      check("R2 plain tail quiet", o_valid, 0);
    end
  endtask

  task automatic t_stray();
    for (int k = 0; k < 4; k++) begin
      word(1'b0, 32'h0100_0000, 1);
      check("R12 stray word", o_valid, 0);
    end
  endtask

  task automatic t_restart();
    word(1'b1, {16'd5, PORT[15:0]}, 0);
    word(1'b0, 32'h0200_0000, 0);
    word(1'b0, 32'h1, 0);
    send_req(8'h01, 32'hbb, 128'h77, 0, 0, 0, "R11 restart");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    @(negedge clk);
    t_opcodes();
    t_hit_window();
    t_plain();
    t_stray();
    t_restart();
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 20000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end
endmodule